// File: doc/BRIEF.md
# DMA Request Front End with Channel Arbiter

This block sits in front of the channel engines of a four-channel DMA controller. Each channel draws its transfer request from one of three places: a pin from outside the chip, a request line from an on-chip peripheral, or a self-generated auto request. Only the two lowest channels own a pin. Each pin passes through a synchronizer, and then through a detector that treats it as an active-low level, an active-high level, a rising edge or a falling edge. An edge is held as a pending request until the channel is served. A level is sampled afresh on every cycle.

The requests from all enabled channels meet in an arbiter. The arbiter works either by fixed order or by rotating order. When the channel engines report that the bus is free, it issues a one-cycle, one-hot grant together with a valid strobe. Moving the data is the job of the channel engines and is not part of this block.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is held, and in the first cycle after it, `grant` is all zero and `grant_valid` is low.
- R2: A grant is issued only at a clock edge where `bus_free` was high and at least one channel requested. The grant lasts exactly one cycle. `grant` has exactly one bit set when `grant_valid` is high, and is all zero when it is low.
- R3: With `rr_mode` low, the requesting channel with the lowest index always wins.
- R4: With `rr_mode` high, the search starts at the channel after the one granted last and wraps from channel 3 to channel 0. After reset the search starts at channel 0.
- R5: The field `src_sel[2c+1:2c]` selects the source of channel c: 00 pin, 01 peripheral, 10 auto, 11 none. A channel set to none, and a channel without a pin (channel 2 or 3) set to pin, never requests.
- R6: A channel set to auto requests on every cycle while it is enabled, so it is granted on each bus-free cycle.
- R7: The field `det_mode[2c+1:2c]` selects the detection of pin c: 00 low level, 01 high level. A level request is granted 3 edges after the pin changes (two synchronizer flops plus the grant register) and is not latched.
- R8: Detection code 10 is rising edge and 11 is falling edge. One edge gives exactly one grant, 4 edges after the pin changes when the bus is free. The edge is held pending while the bus is busy. The opposite edge is ignored.
- R9: A pending edge request is cleared at the edge that grants its channel. Disabling the channel (`ch_enable[c]` low) discards it, and a disabled channel is never granted.
- R10: A peripheral request is a level request and is granted at the first clock edge at which it and `bus_free` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_enable | input | 4 | Per-channel enable |
| src_sel | input | 8 | Request source, two bits per channel |
| det_mode | input | 4 | Pin detection mode, two bits per pin channel |
| ext_req | input | 2 | Asynchronous request pins of channels 0 and 1 |
| periph_req | input | 4 | Peripheral request lines, one per channel |
| rr_mode | input | 1 | 1 = rotating priority, 0 = fixed priority |
| bus_free | input | 1 | Channel engines can accept a new grant |
| grant | output | 4 | One-hot channel grant |
| grant_valid | output | 1 | Grant strobe |

## Verification
Each result has its own delay, counted in clock edges from the edge after the input changes. A peripheral or auto request is granted 1 edge later. A pin level is granted 3 edges later. A pin edge is granted 4 edges later, or at the first edge after the bus becomes free if it has been waiting. The driver tasks count bench cycles and record, for every grant they expect, the exact cycle as well as the channel. The monitor samples on the falling clock edge and matches each strobe against both values. Each scenario that must produce no grant keeps `bus_free` open over a window longer than the slowest of these delays and then checks that no strobe appeared.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;
   typedef enum logic [1:0] {
      DET_LOW  = 2'b00,
      DET_HIGH = 2'b01,
      DET_RISE = 2'b10,
      DET_FALL = 2'b11
   } det_mode_e;

   typedef enum logic [1:0] {
      SRC_PIN    = 2'b00,
      SRC_PERIPH = 2'b01,
      SRC_AUTO   = 2'b10,
      SRC_NONE   = 2'b11
   } req_src_e;
endpackage

// File: rtl/dmarq_sync.sv
module dmarq_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dmarq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("dmarq_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= din;
         end
      end else begin : g_rest
         always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/dmarq_detect.sv
module dmarq_detect
   import dmarq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sync_in,
   input  det_mode_e mode,
   input  logic      armed,
   input  logic      clear,
   output logic      req
);
   logic prev_q;
   logic pend_q;
   logic edge_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= sync_in;
   end

   always_comb begin
      unique case (mode)
         DET_RISE: edge_hit = sync_in & ~prev_q;
         DET_FALL: edge_hit = ~sync_in & prev_q;
         default:  edge_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        pend_q <= 1'b0;
      else if (!armed)   pend_q <= 1'b0;
      else if (edge_hit) pend_q <= 1'b1;
      else if (clear)    pend_q <= 1'b0;
   end

   always_comb begin
      unique case (mode)
         DET_LOW:  req = armed & ~sync_in;
         DET_HIGH: req = armed & sync_in;
         default:  req = armed & pend_q;
      endcase
   end

   AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && edge_hit) |=> pend_q) else $error("edge not latched"); // R8
   AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (clear && !edge_hit && (mode == DET_RISE || mode == DET_FALL)) |=> !req)
      else $error("pending kept after grant"); // R9
   AST_DISARM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && $stable(mode) && (mode == DET_RISE || mode == DET_FALL)) |=> !pend_q || armed)
      else $error("pending survived disable"); // R9
endmodule

// File: rtl/dmarq_arbiter.sv
module dmarq_arbiter #(
   parameter int NUM_CH    = 4,
   parameter bit RR_ENABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   input  logic              rr_mode,
   input  logic              bus_free,
   output logic [NUM_CH-1:0] take,
   output logic [NUM_CH-1:0] grant,
   output logic              grant_valid
);
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

   if (NUM_CH < 2) begin : g_bad_ch
      $error("dmarq_arbiter: NUM_CH must be at least 2");
   end

   logic            use_rr;
   logic [CH_W-1:0] last_q;
   logic [CH_W-1:0] pick_idx;
   logic            found;

   if (RR_ENABLE) begin : g_rotating
      assign use_rr = rr_mode;
   end else begin : g_fixed_only
      assign use_rr = 1'b0;
   end

   always_comb begin
      int start_i;
      int idx_i;
      found    = 1'b0;
      pick_idx = '0;
      start_i  = use_rr ? (int'(last_q) + 1) : 0;
      for (int i = 0; i < NUM_CH; i++) begin
         idx_i = (start_i + i) % NUM_CH;
         if (!found && req[idx_i]) begin
            found    = 1'b1;
            pick_idx = CH_W'(idx_i);
         end
      end
      take = (bus_free && found) ? (NUM_CH'(1) << pick_idx) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         grant       <= '0;
         grant_valid <= 1'b0;
         last_q      <= CH_W'(NUM_CH - 1);
      end else begin
         grant       <= take;
         grant_valid <= bus_free && found;
         if (bus_free && found) last_q <= pick_idx;
      end
   end

   AST_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> $countones(grant) == 1) else $error("grant not one-hot"); // R2
   AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !grant_valid |-> grant == '0) else $error("grant without strobe"); // R2
   AST_NEED_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> $past(bus_free)) else $error("grant while bus busy"); // R2
   AST_WAS_ASKED: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> ($past(req) & grant) != '0) else $error("grant to idle channel"); // R5
   AST_FIXED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !$past(use_rr)) |-> ((grant - NUM_CH'(1)) & $past(req)) == '0)
      else $error("lower channel skipped"); // R3

   if (RR_ENABLE) begin : g_rr_check
      AST_RR_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
         (grant_valid && $past(grant_valid) && $past(rr_mode) && $countones($past(req)) > 1)
         |-> grant != $past(grant)) else $error("rotation repeated a channel"); // R4
   end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
   import dmarq_pkg::*;
#(
   parameter int NUM_CH      = 4,
   parameter int NUM_PIN     = 2,
   parameter int SYNC_STAGES = 2,
   parameter bit RR_ENABLE   = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_CH-1:0]    ch_enable,
   input  logic [2*NUM_CH-1:0]  src_sel,
   input  logic [2*NUM_PIN-1:0] det_mode,
   input  logic [NUM_PIN-1:0]   ext_req,
   input  logic [NUM_CH-1:0]    periph_req,
   input  logic                 rr_mode,
   input  logic                 bus_free,
   output logic [NUM_CH-1:0]    grant,
   output logic                 grant_valid
);
   if (NUM_PIN < 1 || NUM_PIN > NUM_CH) begin : g_bad_pins
      $error("dma_req_arbiter: NUM_PIN must lie in 1..NUM_CH");
   end

   logic [NUM_PIN-1:0] pin_sync;
   logic [NUM_CH-1:0]  pin_hit;
   logic [NUM_CH-1:0]  req_vec;
   logic [NUM_CH-1:0]  take;

   dmarq_sync #(.WIDTH(NUM_PIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (ext_req),
      .dout (pin_sync)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      req_src_e src;
      assign src = req_src_e'(src_sel[2*c +: 2]);

      if (c < NUM_PIN) begin : g_pin
         dmarq_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_in(pin_sync[c]),
            .mode   (det_mode_e'(det_mode[2*c +: 2])),
            .armed  (ch_enable[c] && src == SRC_PIN),
            .clear  (take[c]),
            .req    (pin_hit[c])
         );
      end else begin : g_nopin
         assign pin_hit[c] = 1'b0;
      end

      assign req_vec[c] = (ch_enable[c] &&
                           ((src == SRC_PERIPH && periph_req[c]) || src == SRC_AUTO))
                          || pin_hit[c];
   end

   dmarq_arbiter #(.NUM_CH(NUM_CH), .RR_ENABLE(RR_ENABLE)) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req_vec),
      .rr_mode    (rr_mode),
      .bus_free   (bus_free),
      .take       (take),
      .grant      (grant),
      .grant_valid(grant_valid)
   );

   AST_ENABLED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      grant_valid |-> ($past(ch_enable) & grant) != '0) else $error("disabled channel granted"); // R9
   AST_RESET_QUIET: assert property (@(posedge clk)
      $past(!rst_n) |-> (!grant_valid && grant == '0)) else $error("grant out of reset"); // R1
endmodule

// File: tb/dma_req_arbiter_test.sv
`timescale 1ns/1ps
module dma_req_arbiter_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] ch_enable = '0;
   logic [7:0] src_sel = '0;
   logic [3:0] det_mode = '0;
   logic [1:0] ext_req = '0;
   logic [3:0] periph_req = '0;
   logic       rr_mode = 1'b0;
   logic       bus_free = 1'b0;
   logic [3:0] grant;
   logic       grant_valid;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   int n_grants = 0;
   int idle_bad = 0;
   bit done = 1'b0;

   logic [3:0] eg_q [$];
   int         ec_q [$];
   string      et_q [$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dma_req_arbiter uut (
      .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .src_sel(src_sel),
      .det_mode(det_mode), .ext_req(ext_req), .periph_req(periph_req),
      .rr_mode(rr_mode), .bus_free(bus_free), .grant(grant), .grant_valid(grant_valid)
   );

   // monitor: pop the expected grant and compare channel and cycle
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (grant_valid) begin
            n_grants++;
            checks++;
            if (eg_q.size() == 0) begin
               fails++;
               $display("FAIL R2 unexpected grant: got %b at cycle %0d, expected none", grant, cyc);
            end else begin
               automatic logic [3:0] eg = eg_q.pop_front();
               automatic int         ec = ec_q.pop_front();
               automatic string      et = et_q.pop_front();
               if (grant !== eg || cyc != ec) begin
                  fails++;
                  $display("FAIL %s grant: got %b at cycle %0d, expected %b at cycle %0d",
                           et, grant, cyc, eg, ec);
               end
            end
         end else if (grant !== 4'b0000) begin
            idle_bad++;
         end
      end
   end

   task automatic finish_up();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #(4 * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      finish_up();
   end

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic expect_g(logic [3:0] g, int at, string tag);
      eg_q.push_back(g);
      ec_q.push_back(at);
      et_q.push_back(tag);
   endtask

   task automatic free_for(int k);
      bus_free = 1'b1;
      tick(k);
      bus_free = 1'b0;
   endtask

   task automatic win_done(string tag);
      tick(2);
      checks++;
      if (eg_q.size() != 0) begin
         fails++;
         $display("FAIL %s missing grants: got %0d outstanding, expected 0", tag, eg_q.size());
         eg_q.delete(); ec_q.delete(); et_q.delete();
      end
   endtask

   task automatic expect_none(int k, string tag);
      automatic int base = n_grants;
      free_for(k);
      tick(1);
      checks++;
      if (n_grants != base) begin
         fails++;
         $display("FAIL %s grants in quiet window: got %0d, expected 0", tag, n_grants - base);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
   endtask

   initial begin
      int n;
      tick(3);
      // R1: outputs quiet during reset
      checks++;
      if (grant !== 4'b0000 || grant_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 in reset: got %b/%b, expected 0000/0", grant, grant_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (grant !== 4'b0000 || grant_valid !== 1'b0) begin
         fails++;
         $display("FAIL R1 after reset: got %b/%b, expected 0000/0", grant, grant_valid);
      end
      tick(1);

      // R10: peripheral pulse on channel 2, granted one edge later
      ch_enable = 4'b0100; src_sel = 8'h10;
      tick(1);
      n = cyc;
      periph_req[2] = 1'b1; bus_free = 1'b1;
      expect_g(4'b0100, n + 1, "R10");
      tick(1);
      periph_req[2] = 1'b0;
      tick(1);
      bus_free = 1'b0;
      win_done("R10");

      // R3: fixed order with channels 1..3 asking
      ch_enable = 4'b1110; src_sel = 8'h55; periph_req = 4'b1110; rr_mode = 1'b0;
      tick(1);
      expect_g(4'b0010, cyc + 1, "R3");
      expect_g(4'b0010, cyc + 2, "R3");
      free_for(2);
      periph_req = 4'b1100;
      tick(1);
      expect_g(4'b0100, cyc + 1, "R3");
      free_for(1);
      win_done("R3");
      periph_req = '0;

      // R4: rotation after a reset starts at channel 0
      do_reset();
      ch_enable = 4'b1011; src_sel = 8'h55; periph_req = 4'b1011; rr_mode = 1'b1;
      tick(1);
      expect_g(4'b0001, cyc + 1, "R4");
      expect_g(4'b0010, cyc + 2, "R4");
      expect_g(4'b1000, cyc + 3, "R4");
      expect_g(4'b0001, cyc + 4, "R4");
      free_for(4);
      win_done("R4");
      periph_req = '0; rr_mode = 1'b0;

      // R6: auto request on channel 3 repeats, stops when disabled
      ch_enable = 4'b1000; src_sel = 8'h80;
      tick(1);
      expect_g(4'b1000, cyc + 1, "R6");
      expect_g(4'b1000, cyc + 2, "R6");
      expect_g(4'b1000, cyc + 3, "R6");
      free_for(3);
      win_done("R6");
      ch_enable = 4'b0000;
      expect_none(3, "R6 disabled auto");

      // R5: pin source on channel 2, none source on 3, peripheral ch0 with pin active
      ch_enable = 4'b1101; src_sel = 8'hC1; periph_req = 4'b1000;
      det_mode = 4'b0001; ext_req = 2'b01;
      tick(3);
      expect_none(5, "R5");
      ext_req = 2'b00; periph_req = '0;
      tick(3);

      // R2: requests held but bus never free
      ch_enable = 4'b0001; src_sel = 8'h01; periph_req = 4'b0001;
      begin
         automatic int base = n_grants;
         tick(6);
         checks++;
         if (n_grants != base) begin
            fails++;
            $display("FAIL R2 busy bus: got %0d grants, expected 0", n_grants - base);
         end
      end
      periph_req = '0;

      // R7: high level on pin 0, one-cycle pulse, 3 edges
      ch_enable = 4'b0001; src_sel = 8'h00; det_mode = 4'b0001; ext_req = 2'b00;
      tick(3);
      bus_free = 1'b1;
      tick(1);
      n = cyc;
      ext_req[0] = 1'b1;
      expect_g(4'b0001, n + 3, "R7 high level");
      tick(1);
      ext_req[0] = 1'b0;
      tick(4);
      bus_free = 1'b0;
      win_done("R7");

      // R7: low level on pin 1
      ch_enable = 4'b0000; ext_req[1] = 1'b1; det_mode = 4'b0001;
      tick(3);
      ch_enable = 4'b0010;
      tick(1);
      bus_free = 1'b1;
      tick(1);
      n = cyc;
      ext_req[1] = 1'b0;
      expect_g(4'b0010, n + 3, "R7 low level");
      tick(1);
      ext_req[1] = 1'b1;
      tick(4);
      bus_free = 1'b0;
      win_done("R7");

      // R8: rising edge on pin 0 held while busy, one grant
      ch_enable = 4'b0001; det_mode = 4'b1110;
      tick(3);
      ext_req[0] = 1'b1;
      tick(6);
      expect_g(4'b0001, cyc + 1, "R8 held rising edge");
      free_for(3);
      win_done("R8");
      ext_req[0] = 1'b0;
      expect_none(6, "R8 falling ignored in rising mode");

      // R8/R9: falling edge on pin 1, 4 edges, single grant then cleared
      ch_enable = 4'b0010;
      tick(2);
      bus_free = 1'b1;
      tick(1);
      n = cyc;
      ext_req[1] = 1'b0;
      expect_g(4'b0010, n + 4, "R8 falling edge");
      tick(7);
      bus_free = 1'b0;
      win_done("R9 pending cleared after one grant");

      // R9: pending edge discarded by disable
      ch_enable = 4'b0001;
      tick(1);
      ext_req[0] = 1'b1;
      tick(5);
      ch_enable = 4'b0000;
      tick(2);
      ch_enable = 4'b0001;
      tick(1);
      expect_none(4, "R9 disable drops pending");

      // R2: grant zero whenever strobe is low
      checks++;
      if (idle_bad != 0) begin
         fails++;
         $display("FAIL R2 idle grant: got %0d nonzero idle cycles, expected 0", idle_bad);
      end
      finish_up();
   end
endmodule